// File: doc/BRIEF.md
# VRAM Scroll Offset Address Generator

This block holds the start offset of the frame buffer and adds it to every address that reaches video memory, so that the whole picture can be scrolled by rewriting one register instead of moving pixel data. The same offset is applied to two address streams: the processor's accesses into the plane and the display controller's fetch addresses. Because both streams use one offset, drawing code and the raster always agree on where a pixel lives.

The offset is loaded through two byte-wide write strobes. The upper byte is held in a staging register, and the new value becomes active only when the lower byte is written. The stored offset is then gated by two mode inputs before it is added. The top offset bit counts only when tall-screen (400-line) operation is selected. The five finest bits count only when the fine-scroll enable input is high. The sums wrap inside the plane: 16 KB when the short screen is selected, 32 KB in tall-screen mode. Address decoding and video timing are outside this block.

Top module: `vram_scroll_offset`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the stored offset is zero, so each output equals its input address wrapped to the plane size.
- R2: A write to the upper byte alone (hi_wr) leaves both output addresses unchanged until the lower byte is written.
- R3: A lower-byte write (lo_wr) in one cycle makes the offset {staged upper 7 bits, lo_data} active from the following clock edge. Offset bit 8+i comes from upper-byte bit i (i = 0..6).
- R4: Bit 7 of the upper byte is ignored. Offset bit 14 is added only while mode_400 is 1 and is treated as 0 while mode_400 is 0.
- R5: Offset bits 4..0 are added only while fine_en is 1 and are treated as 0 while fine_en is 0.
- R6: While mode_400 is 0, the output is (address + offset) modulo 16384, so output bit 14 is always 0.
- R7: While mode_400 is 1, the output is (address + offset) modulo 32768.
- R8: The CPU path and the display path apply the same effective offset: equal input addresses give equal outputs.
- R9: The stored offset bits are kept when mode_400 or fine_en change. Changing either input changes the outputs right away, without a new register write.
- R10: If hi_wr and lo_wr occur in the same cycle, the committed offset uses the incoming hi_data, not the previously staged byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_wr | input | 1 | Strobe that stages the upper offset byte |
| hi_data | input | 8 | Upper offset byte (bits 6..0 used) |
| lo_wr | input | 1 | Strobe that writes the lower byte and commits the offset |
| lo_data | input | 8 | Lower offset byte |
| mode_400 | input | 1 | Tall-screen mode: 32 KB plane and offset bit 14 active |
| fine_en | input | 1 | Enables offset bits 4..0 |
| cpu_addr | input | 15 | Processor address within the plane |
| disp_addr | input | 15 | Display fetch address within the plane |
| cpu_addr_out | output | 15 | Offset-adjusted processor address |
| disp_addr_out | output | 15 | Offset-adjusted display address |

## Verification
The only internal state is the staged upper byte and the active offset, and both appear at the ports one clock after the lower-byte write: a wrong commit or a stray update shows up as a displaced address on both paths in that same cycle. A fault in the staging register shows only after the next lower-byte write, so the tests stage an upper byte, probe the outputs, and then commit it. Gating faults show up combinationally as soon as mode_400 or fine_en changes, so these inputs are toggled over one stored offset without rewriting it.

// File: rtl/vso_pkg.sv
// Package: shared widths and types for the scroll offset generator.
// Assumes a 15-bit plane address (32 KB tall-screen plane, 16 KB short).
package vso_pkg;
    localparam int ADDR_W  = 15;              // widest plane address
    localparam int BYTE_W  = 8;               // write port width
    localparam int UPPER_W = ADDR_W - BYTE_W; // offset bits held in the upper byte
    localparam int FINE_W  = 5;               // fine-scroll bits gated by enable
    localparam int NUM_PATHS = 2;             // CPU path and display path

    typedef logic [ADDR_W-1:0] vaddr_t;
endpackage

// File: rtl/vso_offset_regs.sv
// Module: vso_offset_regs
// Stages the upper offset byte and commits the full offset on a lower-byte
// write, so consumers never see a half-written offset.
// Assumes write strobes are single-cycle pulses in the clk domain.
module vso_offset_regs
    import vso_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BYTE_W,
    localparam int UW = AW - BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hi_wr,
    input  logic [BW-1:0] hi_data,
    input  logic          lo_wr,
    input  logic [BW-1:0] lo_data,
    output logic [AW-1:0] offset_q
);
    logic [UW-1:0] staged_hi;
    logic [UW-1:0] hi_next;

    // Pick the upper bits for a commit: the incoming byte wins on a same-cycle write.
    always_comb begin
        hi_next = hi_wr ? hi_data[UW-1:0] : staged_hi;
    end

    // Hold the staged upper byte.
    always_ff @(posedge clk) begin
        if (!rst_n)     staged_hi <= '0;
        else if (hi_wr) staged_hi <= hi_data[UW-1:0];
    end

    // Commit the full offset when the lower byte arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)     offset_q <= '0;
        else if (lo_wr) offset_q <= {hi_next, lo_data};
    end

    // R1: reset clears the active offset.
    a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> (offset_q == '0));
    // R2: without a lower-byte write the active offset holds.
    a_r2_hold_offset: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_wr |=> $stable(offset_q));
    // R3: the lower byte lands in the low offset bits.
    a_r3_low_commit: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> (offset_q[BW-1:0] == $past(lo_data)));
    // R10: a same-cycle upper write feeds the commit.
    a_r10_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && hi_wr) |=> (offset_q[AW-1:BW] == $past(hi_data[UW-1:0])));
endmodule

// File: rtl/vso_offset_gate.sv
// Module: vso_offset_gate
// Masks the stored offset by mode: the top bit needs tall-screen mode and
// the fine bits need the fine-scroll enable. Purely combinational.
module vso_offset_gate
    import vso_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int FW = FINE_W
) (
    input  logic [AW-1:0] offset_raw,
    input  logic          mode_400,
    input  logic          fine_en,
    output logic [AW-1:0] offset_eff
);
    // Clear the bits the current mode does not allow.
    always_comb begin
        offset_eff = offset_raw;
        if (!mode_400) offset_eff[AW-1]   = 1'b0;
        if (!fine_en)  offset_eff[FW-1:0] = '0;
    end
endmodule

// File: rtl/vso_addr_wrap.sv
// Module: vso_addr_wrap
// Adds the effective offset to one address and wraps inside the plane:
// full width in tall-screen mode, one bit less otherwise.
module vso_addr_wrap
    import vso_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr_in,
    input  logic [AW-1:0] offset_eff,
    input  logic          mode_400,
    output logic [AW-1:0] addr_out
);
    logic [AW-1:0] sum;

    // Modular add, then drop the top bit for the short plane.
    always_comb begin
        sum      = addr_in + offset_eff;
        addr_out = sum;
        if (!mode_400) addr_out[AW-1] = 1'b0;
    end
endmodule

// File: rtl/vram_scroll_offset.sv
// Module: vram_scroll_offset (top)
// Holds the scroll offset and applies it identically to the CPU and display
// address paths. Assumes addresses arrive already within the plane.
module vram_scroll_offset
    import vso_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_wr,
    input  logic [BYTE_W-1:0] hi_data,
    input  logic              lo_wr,
    input  logic [BYTE_W-1:0] lo_data,
    input  logic              mode_400,
    input  logic              fine_en,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [ADDR_W-1:0] disp_addr,
    output logic [ADDR_W-1:0] cpu_addr_out,
    output logic [ADDR_W-1:0] disp_addr_out
);
    vaddr_t offset_q;
    vaddr_t offset_eff;
    vaddr_t path_in  [NUM_PATHS];
    vaddr_t path_out [NUM_PATHS];

    vso_offset_regs #(.AW(ADDR_W), .BW(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .hi_wr(hi_wr), .hi_data(hi_data),
        .lo_wr(lo_wr), .lo_data(lo_data),
        .offset_q(offset_q)
    );

    vso_offset_gate #(.AW(ADDR_W), .FW(FINE_W)) u_gate (
        .offset_raw(offset_q), .mode_400(mode_400), .fine_en(fine_en),
        .offset_eff(offset_eff)
    );

    // Route the two address streams into the path array.
    always_comb begin
        path_in[0] = cpu_addr;
        path_in[1] = disp_addr;
    end

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        vso_addr_wrap #(.AW(ADDR_W)) u_wrap (
            .addr_in(path_in[p]), .offset_eff(offset_eff),
            .mode_400(mode_400), .addr_out(path_out[p])
        );
    end

    assign cpu_addr_out  = path_out[0];
    assign disp_addr_out = path_out[1];

    // R8: both paths share one offset.
    a_r8_same_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == disp_addr) |-> (cpu_addr_out == disp_addr_out));
    // R6: the short plane never produces bit 14.
    a_r6_short_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_400 |-> (cpu_addr_out[ADDR_W-1] == 1'b0 && disp_addr_out[ADDR_W-1] == 1'b0));
    // R5: without fine enable the low bits pass through unchanged.
    a_r5_coarse_only: assert property (@(posedge clk) disable iff (!rst_n)
        !fine_en |-> (cpu_addr_out[FINE_W-1:0] == cpu_addr[FINE_W-1:0]));
endmodule

// File: tb/vram_scroll_offset_bench.sv
// Directed bench for vram_scroll_offset; one task per scenario.
module vram_scroll_offset_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hi_wr = 1'b0, lo_wr = 1'b0;
    logic [7:0]  hi_data = '0, lo_data = '0;
    logic        mode_400 = 1'b0, fine_en = 1'b0;
    logic [14:0] cpu_addr = '0, disp_addr = '0;
    logic [14:0] cpu_addr_out, disp_addr_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Bench model of the committed offset and the staged upper byte.
    logic [14:0] m_off = '0;
    logic [6:0]  m_hi  = '0;

    always #4 clk = ~clk;

    vram_scroll_offset u_vram_scroll_offset (
        .clk(clk), .rst_n(rst_n),
        .hi_wr(hi_wr), .hi_data(hi_data),
        .lo_wr(lo_wr), .lo_data(lo_data),
        .mode_400(mode_400), .fine_en(fine_en),
        .cpu_addr(cpu_addr), .disp_addr(disp_addr),
        .cpu_addr_out(cpu_addr_out), .disp_addr_out(disp_addr_out)
    );

    function automatic logic [14:0] expect_addr(input logic [14:0] a);
        logic [14:0] e;
        logic [14:0] s;
        e = m_off;
        if (!mode_400) e[14] = 1'b0;
        if (!fine_en)  e[4:0] = '0;
        s = a + e;
        if (!mode_400) s[14] = 1'b0;
        return s;
    endfunction

    task automatic check_both(input string req, input logic [14:0] ca, input logic [14:0] da);
        logic [14:0] ec, ed;
        cpu_addr = ca;
        disp_addr = da;
        #1;
        ec = expect_addr(ca);
        ed = expect_addr(da);
        checks++;
        if (cpu_addr_out !== ec || disp_addr_out !== ed) begin
            errors++;
            $display("FAIL %s: cpu=%h disp=%h expected cpu=%h disp=%h",
                     req, cpu_addr_out, disp_addr_out, ec, ed);
        end
    endtask

    task automatic write_hi(input logic [7:0] v);
        @(negedge clk);
        hi_wr = 1'b1; hi_data = v;
        @(negedge clk);
        hi_wr = 1'b0;
        m_hi = v[6:0];
    endtask

    task automatic write_lo(input logic [7:0] v);
        @(negedge clk);
        lo_wr = 1'b1; lo_data = v;
        @(negedge clk);
        lo_wr = 1'b0;
        m_off = {m_hi, v};
    endtask

    task automatic t_reset();
        mode_400 = 1'b0; fine_en = 1'b1;
        check_both("R1", 15'h1234, 15'h7FFF);
        mode_400 = 1'b1;
        check_both("R1", 15'h5A5A, 15'h0001);
    endtask

    task automatic t_hi_only();
        mode_400 = 1'b1; fine_en = 1'b1;
        write_hi(8'h25);
        // model m_off unchanged until lo write
        check_both("R2", 15'h0100, 15'h3000);
    endtask

    task automatic t_commit();
        write_lo(8'h40);
        check_both("R3", 15'h0000, 15'h0123);
    endtask

    task automatic t_top_bit();
        write_hi(8'hFF);
        write_lo(8'h00);
        mode_400 = 1'b0;
        check_both("R4", 15'h0010, 15'h0200);
        mode_400 = 1'b1;
        check_both("R4", 15'h0010, 15'h0200);
        write_hi(8'h7F);
        write_lo(8'h00);
        check_both("R4", 15'h0010, 15'h0200);
    endtask

    task automatic t_fine();
        write_hi(8'h00);
        write_lo(8'h1F);
        fine_en = 1'b0;
        check_both("R5", 15'h0100, 15'h0003);
        fine_en = 1'b1;
        check_both("R5", 15'h0100, 15'h0003);
    endtask

    task automatic t_wrap_short();
        mode_400 = 1'b0; fine_en = 1'b1;
        write_hi(8'h20);
        write_lo(8'h10);
        check_both("R6", 15'h3FF8, 15'h1FF0);
    endtask

    task automatic t_wrap_tall();
        mode_400 = 1'b1;
        write_hi(8'h60);
        write_lo(8'h01);
        check_both("R7", 15'h7FFF, 15'h2000);
    endtask

    task automatic t_same();
        check_both("R8", 15'h4321, 15'h4321);
        mode_400 = 1'b0;
        check_both("R8", 15'h0ABC, 15'h0ABC);
    endtask

    task automatic t_persist();
        write_hi(8'h44);
        write_lo(8'h0F);
        mode_400 = 1'b0; fine_en = 1'b0;
        check_both("R9", 15'h0000, 15'h1111);
        mode_400 = 1'b1;
        check_both("R9", 15'h0000, 15'h1111);
        fine_en = 1'b1;
        check_both("R9", 15'h0000, 15'h1111);
    endtask

    task automatic t_same_cycle();
        write_hi(8'h11);
        @(negedge clk);
        hi_wr = 1'b1; hi_data = 8'h33;
        lo_wr = 1'b1; lo_data = 8'h99;
        @(negedge clk);
        hi_wr = 1'b0; lo_wr = 1'b0;
        m_hi = 7'h33;
        m_off = {7'h33, 8'h99};
        check_both("R10", 15'h0002, 15'h0400);
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_off = '0; m_hi = '0;
        check_both("R1", 15'h2222, 15'h6666);
        write_lo(8'h08);
        check_both("R1", 15'h0000, 15'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hi_only();
        t_commit();
        t_top_bit();
        t_fine();
        t_wrap_short();
        t_wrap_tall();
        t_same();
        t_persist();
        t_same_cycle();
        t_reset_again();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule